// File: doc/BRIEF.md
# Electrically Erasable Byte Memory Control Model

This block is a synthesizable behavioural model of the control side of a byte-wide, many-time-programmable memory that presents a classic EPROM-style interface. Two active-low strobes (chip enable and output enable) and two digital qualifiers select the operating mode. One qualifier says that the ninth address line carries a super-voltage. The other says that the programming supply is at its high level. The modes are read, output disable, standby, program/erase inhibit, identification, byte program and whole-array erase.

The model owns a small byte array whose depth is a parameter. Reads and identification bytes appear on a byte output that comes with a drive-enable flag, which stands in for a tri-state bus. A program or erase operation is a chip-enable-low pulse that starts at the falling edge of chip enable. Its length is counted in clock cycles and compared against minimum widths given as parameters. A pulse that is too short, or one whose mode qualifiers change before chip enable returns high, leaves the array untouched and sets a sticky error flag.

All inputs are sampled on the rising clock edge. High-voltage levels and analog behaviour are reduced to the two qualifier bits.

Top module: `mtp_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every byte of the array reads 0xFF, the error flag is 0, and with ce_n high the output is not driven.
- R2: dq_oe is 1 only while ce_n and oe_n are both 0. Whenever dq_oe is 0, dq_out is 0x00.
- R3: With ce_n=0, oe_n=0 and a9_hv=0, dq_out shows the byte stored at addr.
- R4: With ce_n=0, oe_n=0, a9_hv=1 and vpp_hv=0, dq_out is 0xBF when addr bit 0 is 0 and 0xC7 when addr bit 0 is 1.
- R5: A program pulse has these conditions: oe_n=1, vpp_hv=1 and a9_hv=0 at the falling edge of ce_n. The addr and din sampled at the first low edge are captured. If ce_n is sampled low on at least PROG_MIN_CYC edges before it is sampled high, the captured byte is written when ce_n returns high.
- R6: Programming stores the old byte ANDed with the data, so no bit of a programmed byte goes from 0 to 1.
- R7: An erase pulse has these conditions: oe_n=1, vpp_hv=1 and a9_hv=1 at the falling edge of ce_n. If it lasts at least ERASE_MIN_CYC low edges, every byte becomes 0xFF.
- R8: A program or erase pulse with fewer low edges than its minimum leaves the array unchanged and sets pulse_err.
- R9: While ce_n=1 and vpp_hv=1 (inhibit), changes on addr, din, oe_n and a9_hv alter neither the output (not driven) nor the array.
- R10: If oe_n, vpp_hv or a9_hv change while a program or erase pulse holds ce_n low, the pulse is cancelled, the array is unchanged and pulse_err is set.
- R11: A falling edge of ce_n with vpp_hv=0 (read, output-disable or identification mode) writes nothing.
- R12: Once set, pulse_err stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low; its low pulse times program and erase |
| oe_n | input | 1 | Output enable, active low |
| a9_hv | input | 1 | Super-voltage present on address line 9 |
| vpp_hv | input | 1 | Programming supply at high level |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data to program |
| dq_out | output | 8 | Byte output; 0x00 while not driven |
| dq_oe | output | 1 | Output drive enable; 0 means high impedance |
| pulse_err | output | 1 | Sticky flag for a short or cancelled pulse |

## Verification
The bench builds the block with a 16-byte array, a program minimum of 6 cycles and an erase minimum of 12 cycles. With these values, pulses that are exactly at the minimum and one cycle below it take only a few dozen cycles. It also lets a full erase be checked against every address. Because the array is this small, the bench can keep a complete shadow copy of the array. It can then read back whole-array effects, such as an erase or the absence of stray writes, at each address.

// File: rtl/mtp_pkg.sv
// Shared types for the MTP control model.
// Assumes: byte-wide data; identification codes are fixed constants.
package mtp_pkg;
    typedef enum logic [2:0] {
        MD_STANDBY = 3'd0,
        MD_INHIBIT = 3'd1,
        MD_READ    = 3'd2,
        MD_OUTOFF  = 3'd3,
        MD_IDENT   = 3'd4,
        MD_PROG    = 3'd5,
        MD_ERASE   = 3'd6
    } mtp_mode_t;

    localparam logic [7:0] ID_MAKER  = 8'hBF;
    localparam logic [7:0] ID_DEVICE = 8'hC7;
    localparam logic [7:0] ERASED    = 8'hFF;
endpackage

// File: rtl/mtp_mode_dec.sv
// Mode decoder: maps the strobes and the two high-voltage qualifiers onto
// one operating mode. Purely combinational.
// Assumes: with oe_n low, a9_hv high and vpp_hv high the part reads the
// array (program verify), not the identification bytes.
module mtp_mode_dec
    import mtp_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      a9_hv,
    input  logic      vpp_hv,
    output mtp_mode_t mode
);
    // Priority decode: chip enable first, then output enable, then supply.
    always_comb begin
        if (ce_n) begin
            mode = vpp_hv ? MD_INHIBIT : MD_STANDBY;
        end else if (!oe_n) begin
            mode = (a9_hv && !vpp_hv) ? MD_IDENT : MD_READ;
        end else if (vpp_hv) begin
            mode = a9_hv ? MD_ERASE : MD_PROG;
        end else begin
            mode = MD_OUTOFF;
        end
    end
endmodule

// File: rtl/mtp_pulse_timer.sv
// Pulse timer: detects the falling edge of chip enable in program or erase
// mode, captures address and data, counts low cycles and, when chip enable
// rises, reports a commit or a fault. A change of mode mid-pulse cancels it.
// Assumes: ce_n is synchronous to clk; minimum widths are at least 1.
module mtp_pulse_timer
    import mtp_pkg::*;
#(
    parameter int ADDR_W        = 4,
    parameter int PROG_MIN_CYC  = 1000,
    parameter int ERASE_MIN_CYC = 10_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  mtp_mode_t         mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              commit_prog,
    output logic              commit_erase,
    output logic              fault,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    localparam int MAX_MIN = (ERASE_MIN_CYC > PROG_MIN_CYC) ? ERASE_MIN_CYC : PROG_MIN_CYC;
    localparam int CW      = $clog2(MAX_MIN + 1);

    logic          ce_q;
    logic          active;
    mtp_mode_t     kind;
    logic [CW-1:0] cnt;
    logic [CW-1:0] target;
    logic          start;
    logic          abort;
    logic          finish;
    logic          long_enough;

    // Edge and qualifier evaluation for the current cycle.
    always_comb begin
        start       = ce_q && !ce_n && (mode == MD_PROG || mode == MD_ERASE);
        abort       = active && !ce_n && (mode != kind);
        finish      = active && ce_n;
        target      = (kind == MD_ERASE) ? CW'(ERASE_MIN_CYC) : CW'(PROG_MIN_CYC);
        long_enough = (cnt >= target);
    end

    // Pulse tracking: capture at start, saturating count while low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q    <= 1'b1;
            active  <= 1'b0;
            kind    <= MD_PROG;
            cnt     <= '0;
            wr_addr <= '0;
            wr_data <= 8'h00;
        end else begin
            ce_q <= ce_n;
            if (start) begin
                active  <= 1'b1;
                kind    <= mode;
                cnt     <= CW'(1);
                wr_addr <= addr;
                wr_data <= din;
            end else if (active) begin
                if (ce_n || abort) begin
                    active <= 1'b0;
                end else if (cnt != target) begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    // Outcome strobes, valid in the cycle ce_n is first sampled high.
    always_comb begin
        commit_prog  = finish && long_enough && (kind == MD_PROG);
        commit_erase = finish && long_enough && (kind == MD_ERASE);
        fault        = (finish && !long_enough) || abort;
    end

    // At most one outcome per cycle (R8, R10).
    p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_prog, commit_erase, fault}));

    // A commit only follows a low-to-high chip enable transition (R5).
    p_commit_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_prog || commit_erase) |-> (ce_n && !$past(ce_n)));

    // A cancelled pulse never commits on the later rise (R10).
    p_abort_no_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !(commit_prog || commit_erase));
endmodule

// File: rtl/mtp_cell_array.sv
// Cell array: DEPTH bytes, reset and erase to all ones, programming by AND.
// Read port is combinational.
// Assumes: erase and program strobes are never high together.
module mtp_cell_array
    import mtp_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_en,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    logic [7:0] mem [DEPTH];

    // Storage update: reset/erase fill with ones, program clears bits only.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= ERASED;
            end
        end else if (prog_en) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    // Read port.
    assign rd_data = mem[rd_addr];

    // After a program, every bit that was 0 in the data is 0 in the cell (R6).
    p_prog_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> ((mem[$past(wr_addr)] & ~$past(wr_data)) == 8'h00));

    // After an erase, the first and last bytes hold all ones (R7).
    p_erase_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> (mem[0] == ERASED && mem[DEPTH-1] == ERASED));
endmodule

// File: rtl/mtp_ctrl.sv
// Top of the MTP control model: decodes the mode, times program/erase
// pulses, holds the byte array, selects the output byte and keeps the
// sticky pulse error flag.
// Assumes: all inputs synchronous to clk; dq_oe low stands for high-Z.
module mtp_ctrl
    import mtp_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter int ADDR_W        = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int PROG_MIN_CYC  = 1000,
    parameter int ERASE_MIN_CYC = 10_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              a9_hv,
    input  logic              vpp_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    output logic              pulse_err
);
    mtp_mode_t         mode;
    logic              commit_prog;
    logic              commit_erase;
    logic              fault;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [7:0]        rd_data;

    mtp_mode_dec u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .a9_hv  (a9_hv),
        .vpp_hv (vpp_hv),
        .mode   (mode)
    );

    mtp_pulse_timer #(
        .ADDR_W        (ADDR_W),
        .PROG_MIN_CYC  (PROG_MIN_CYC),
        .ERASE_MIN_CYC (ERASE_MIN_CYC)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .ce_n         (ce_n),
        .mode         (mode),
        .addr         (addr),
        .din          (din),
        .commit_prog  (commit_prog),
        .commit_erase (commit_erase),
        .fault        (fault),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data)
    );

    mtp_cell_array #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .erase_en (commit_erase),
        .prog_en  (commit_prog),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (addr),
        .rd_data  (rd_data)
    );

    // Output select: drive only in read or identification mode.
    always_comb begin
        dq_oe  = (mode == MD_READ) || (mode == MD_IDENT);
        dq_out = 8'h00;
        if (mode == MD_IDENT) begin
            dq_out = addr[0] ? ID_DEVICE : ID_MAKER;
        end else if (mode == MD_READ) begin
            dq_out = rd_data;
        end
    end

    // Sticky error flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_err <= 1'b0;
        end else if (fault) begin
            pulse_err <= 1'b1;
        end
    end

    // Output is driven only with both strobes low (R2).
    p_drive_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!ce_n && !oe_n));

    // Undriven output is quiet (R2).
    p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_out == 8'h00));

    // Error flag never falls outside reset (R12).
    p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_err |=> pulse_err);
endmodule

// File: tb/sim_mtp_ctrl.sv
module sim_mtp_ctrl;
    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int PMIN  = 6;
    localparam int EMIN  = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_n, oe_n, a9_hv, vpp_hv;
    logic [AW-1:0] addr;
    logic [7:0]    din;
    logic [7:0]    dq_out;
    logic          dq_oe;
    logic          pulse_err;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [7:0] shadow [DEPTH];

    always #5 clk = ~clk;

    mtp_ctrl #(
        .DEPTH         (DEPTH),
        .ADDR_W        (AW),
        .PROG_MIN_CYC  (PMIN),
        .ERASE_MIN_CYC (EMIN)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .a9_hv     (a9_hv),
        .vpp_hv    (vpp_hv),
        .addr      (addr),
        .din       (din),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .pulse_err (pulse_err)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, act=%0d exp<=100000 cycles", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=0x%02h exp=0x%02h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; a9_hv = 1'b0; vpp_hv = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; a9_hv = 1'b0; vpp_hv = 1'b0; addr = a;
        @(negedge clk);
        d = dq_out; oe = dq_oe;
    endtask

    task automatic check_all(input string req);
        logic [7:0] d;
        logic oe;
        for (int i = 0; i < DEPTH; i++) begin
            rd(AW'(i), d, oe);
            chk(req, d, shadow[i]);
        end
    endtask

    // Chip-enable pulse of n low edges; abort_at>0 drops oe_n after that many.
    task automatic pulse(input logic a9, input logic [AW-1:0] a, input logic [7:0] d,
                         input int n, input int abort_at);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; a9_hv = a9; vpp_hv = 1'b1; addr = a; din = d;
        @(negedge clk);
        ce_n = 1'b0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (k == abort_at) oe_n = 1'b0;
        end
        ce_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        vpp_hv = 1'b0; a9_hv = 1'b0; oe_n = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ce_n = 1'b1; oe_n = 1'b1; a9_hv = 1'b0; vpp_hv = 1'b0; addr = '0; din = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 err", {7'd0, pulse_err}, 8'h00);
        chk("R1 oe", {7'd0, dq_oe}, 8'h00);
        check_all("R1 array");
    endtask

    task automatic t_gate();
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; addr = 4'd0;
        @(negedge clk); chk("R2 oe_n high", {dq_oe, dq_out[6:0]}, 8'h00);
        ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk); chk("R2 ce_n high", {dq_oe, dq_out[6:0]}, 8'h00);
        ce_n = 1'b0;
        @(negedge clk); chk("R2 both low", {7'd0, dq_oe}, 8'h01);
        idle();
    endtask

    task automatic t_program();
        logic [7:0] d;
        logic oe;
        pulse(1'b0, 4'd3, 8'hA5, PMIN, 0); shadow[3] = 8'hA5;
        pulse(1'b0, 4'd9, 8'h3C, PMIN + 4, 0); shadow[9] = 8'h3C;
        rd(4'd3, d, oe); chk("R5 prog at min", d, 8'hA5);
        rd(4'd9, d, oe); chk("R3 read addr9", d, 8'h3C);
        rd(4'd4, d, oe); chk("R3 neighbour", d, 8'hFF);
        chk("R5 no err", {7'd0, pulse_err}, 8'h00);
    endtask

    task automatic t_and();
        logic [7:0] d;
        logic oe;
        pulse(1'b0, 4'd3, 8'h5F, PMIN, 0); shadow[3] = shadow[3] & 8'h5F;
        rd(4'd3, d, oe); chk("R6 and", d, 8'h05);
        pulse(1'b0, 4'd3, 8'hFF, PMIN, 0);
        rd(4'd3, d, oe); chk("R6 no regain", d, 8'h05);
    endtask

    task automatic t_short();
        pulse(1'b0, 4'd4, 8'h00, PMIN - 1, 0);
        chk("R8 err set", {7'd0, pulse_err}, 8'h01);
        check_all("R8 unchanged");
        chk("R12 still set", {7'd0, pulse_err}, 8'h01);
        do_reset();
        chk("R12 reset clears", {7'd0, pulse_err}, 8'h00);
    endtask

    task automatic t_ident();
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; a9_hv = 1'b1; vpp_hv = 1'b0; addr = 4'd0;
        @(negedge clk); chk("R4 maker", dq_out, 8'hBF);
        addr = 4'd1;
        @(negedge clk); chk("R4 device", dq_out, 8'hC7);
        chk("R4 driven", {7'd0, dq_oe}, 8'h01);
        idle();
    endtask

    task automatic t_inhibit();
        @(negedge clk); ce_n = 1'b1; vpp_hv = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            addr = AW'(k); din = 8'h00; oe_n = k[0]; a9_hv = k[1];
            @(negedge clk);
            chk("R9 no drive", {dq_oe, dq_out[6:0]}, 8'h00);
        end
        idle();
        check_all("R9 unchanged");
    endtask

    task automatic t_no_vpp_fall();
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; vpp_hv = 1'b0; addr = 4'd6; din = 8'h00;
        @(negedge clk); ce_n = 1'b0;
        repeat (PMIN + 2) @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk); ce_n = 1'b0; addr = 4'd7; a9_hv = 1'b1;
        repeat (PMIN + 2) @(negedge clk);
        idle();
        check_all("R11 no write");
        chk("R11 no err", {7'd0, pulse_err}, 8'h00);
    endtask

    task automatic t_abort();
        pulse(1'b0, 4'd8, 8'h00, PMIN + 2, 2);
        chk("R10 err", {7'd0, pulse_err}, 8'h01);
        check_all("R10 unchanged");
        do_reset();
    endtask

    task automatic t_erase();
        pulse(1'b0, 4'd2, 8'h11, PMIN, 0); shadow[2] = 8'h11;
        pulse(1'b0, 4'd15, 8'h80, PMIN, 0); shadow[15] = 8'h80;
        pulse(1'b1, 4'd0, 8'h00, EMIN - 1, 0);
        chk("R8 erase short err", {7'd0, pulse_err}, 8'h01);
        check_all("R8 erase short");
        pulse(1'b1, 4'd5, 8'h00, EMIN, 0);
        for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
        check_all("R7 erase all ones");
    endtask

    initial begin
        rst_n = 1'b0;
        ce_n = 1'b1; oe_n = 1'b1; a9_hv = 1'b0; vpp_hv = 1'b0; addr = '0; din = 8'h00;
        do_reset();
        t_reset();
        t_gate();
        t_program();
        t_and();
        t_short();
        t_ident();
        t_program();
        t_inhibit();
        t_no_vpp_fall();
        t_abort();
        t_erase();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule